// File: doc/BRIEF.md
# Strobe-Idle Power-Down Controller

This block watches the address-latch strobe of a host microcontroller bus and reports when the bus has gone quiet. When the feature is enabled and the strobe stays at a chosen static level, a saturating counter counts clocks. After exactly fifteen such clocks the power-down output goes high. Any change on the strobe clears the counter, and the output drops at the clock edge that samples that change.

The block also holds two power-management registers. Their bits remove individual signals from the inputs of a downstream logic array: the array clock input, the low address byte, three bus control lines, the strobe and the write-high line. A turbo-disable bit is brought out to the array. An active-low chip-select is decoded into enables for the flash, boot block, SRAM and I/O register space. The chip-select does not affect the gated array inputs.

Top module: `strobe_idle_pm`

## Requirements
- R1: After reset, all three register locations (address 0 configuration, address 1 pm0, address 2 pm2) read 0 and `pwr_down` is 0.
- R2: While configuration bit 0 (enable) is 0, `pwr_down` stays 0 however long the strobe sits still. Clearing the enable bit while `pwr_down` is high drops it one clock after the write.
- R3: With enable set and the strobe held at the idle level, `pwr_down` is 0 after 14 rising clock edges and 1 after the 15th. The count starts at the edge that captured the enabling write or the last strobe change.
- R4: Configuration bit 1 (polarity) chooses the idle level: 0 means the strobe low is idle, 1 means the strobe high is idle. While the strobe sits at the other level, no count builds up.
- R5: A strobe that toggles every clock never raises `pwr_down`. A single strobe change while `pwr_down` is high drops it at the next rising edge.
- R6: Once raised, `pwr_down` stays high for as long as the strobe remains idle. The counter saturates and never wraps.
- R7: A write with `reg_wr` high stores `reg_wdata` at `reg_addr` (0 configuration, 1 pm0, 2 pm2). `reg_rdata` shows the addressed register combinationally. Address 3 reads 0, and a write to it changes no register.
- R8: pm0 bit 3 set makes `turbo_on` 0 (cleared, `turbo_on` is 1). pm0 bit 4 set forces `arr_clk` to 0; cleared, `arr_clk` follows `clk_in`.
- R9: Each pm2 bit set forces its array output to 0. Bit 0 gates `arr_addr`. Bits 2, 3 and 4 gate `arr_ctl[0]`, `arr_ctl[1]` and `arr_ctl[2]`. Bit 5 gates `arr_strb` and bit 6 gates `arr_wrh`. Bits 1 and 7 gate nothing.
- R10: `cs_n` low sets `flash_en`, `boot_en`, `sram_en` and `io_en` to 1. `cs_n` high sets all four to 0 and leaves every `arr_*` output and `turbo_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| strb_in | input | 1 | Bus address-latch strobe |
| cs_n | input | 1 | Active-low chip-select |
| clk_in | input | 1 | Clock input destined for the logic array |
| addr_in | input | 8 | Low address byte from the bus |
| ctl_in | input | 3 | Bus control lines |
| wrh_in | input | 1 | Write-high / byte-enable line |
| pwr_down | output | 1 | Power-down request |
| turbo_on | output | 1 | Array full-speed mode |
| arr_clk | output | 1 | Gated clock input to the array |
| arr_addr | output | 8 | Gated address byte |
| arr_ctl | output | 3 | Gated control lines |
| arr_strb | output | 1 | Gated strobe |
| arr_wrh | output | 1 | Gated write-high line |
| flash_en | output | 1 | Main flash enable |
| boot_en | output | 1 | Boot block enable |
| sram_en | output | 1 | SRAM enable |
| io_en | output | 1 | I/O register space enable |

## Verification
The idle detector is driven with five strobe patterns. A strobe held still with the feature disabled shows that the enable gates the counter. A strobe held at the idle level is checked at clocks 14 and 15, which pins the threshold to the exact edge and then tests saturation. A strobe toggling every clock shows that pulsing suppresses the count. A strobe held at the non-idle level, and then moved to the idle level, tells the polarity choice apart from simple edge detection. The gating bits are each set alone against non-zero bus values, so that a wrong bit-to-signal mapping shows up as a wrong output.

// File: rtl/strobe_idle_pkg.sv
package strobe_idle_pkg;

  localparam int unsigned REG_W = 8;

  localparam logic [1:0] ADR_CFG = 2'd0;
  localparam logic [1:0] ADR_PM0 = 2'd1;
  localparam logic [1:0] ADR_PM2 = 2'd2;

  localparam int unsigned PM0_TURBO_OFF = 3;
  localparam int unsigned PM0_CLK_OFF   = 4;
  localparam int unsigned PM2_ADDR_OFF  = 0;
  localparam int unsigned PM2_CTL0_OFF  = 2;
  localparam int unsigned PM2_STRB_OFF  = 5;
  localparam int unsigned PM2_WRH_OFF   = 6;

  // Next idle count: cleared when stopped or restarted, saturating at limit.
  function automatic int unsigned idle_step(int unsigned cur, logic run,
                                            logic restart, int unsigned limit);
    if (!run || restart) return 0;
    if (cur >= limit) return limit;
    return cur + 1;
  endfunction

endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import strobe_idle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             cfg_en,
  output logic             cfg_pol,
  output logic [REG_W-1:0] pm0,
  output logic [REG_W-1:0] pm2
);

  logic [1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      pm0   <= '0;
      pm2   <= '0;
    end else if (wr) begin
      case (addr)
        ADR_CFG: cfg_q <= wdata[1:0];
        ADR_PM0: pm0   <= wdata;
        ADR_PM2: pm2   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADR_CFG: rdata = {{(REG_W-2){1'b0}}, cfg_q};
      ADR_PM0: rdata = pm0;
      ADR_PM2: rdata = pm2;
      default: rdata = '0;
    endcase
  end

  assign cfg_en  = cfg_q[0];
  assign cfg_pol = cfg_q[1];

endmodule

// File: rtl/idle_counter.sv
module idle_counter
  import strobe_idle_pkg::*;
#(
  parameter int unsigned IDLE_CLKS = 15,
  localparam int unsigned CNT_W = $clog2(IDLE_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic             strb,
  output logic [CNT_W-1:0] cnt,
  output logic             strb_chg,
  output logic             at_idle,
  output logic             pd
);

  logic strb_q;

  assign strb_chg = strb ^ strb_q;
  assign at_idle  = (strb == pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      cnt    <= '0;
    end else begin
      strb_q <= strb;
      cnt    <= CNT_W'(idle_step(int'(cnt), en && at_idle, strb_chg, IDLE_CLKS));
    end
  end

  assign pd = (cnt == CNT_W'(IDLE_CLKS));

endmodule

// File: rtl/bus_gate.sv
module bus_gate
  import strobe_idle_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CTL_W  = 3
) (
  input  logic [REG_W-1:0]  pm0,
  input  logic [REG_W-1:0]  pm2,
  input  logic              clk_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic              strb_in,
  input  logic              wrh_in,
  output logic              turbo_on,
  output logic              arr_clk,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [CTL_W-1:0]  arr_ctl,
  output logic              arr_strb,
  output logic              arr_wrh
);

  assign turbo_on = ~pm0[PM0_TURBO_OFF];
  assign arr_clk  = clk_in & ~pm0[PM0_CLK_OFF];
  assign arr_addr = pm2[PM2_ADDR_OFF] ? '0 : addr_in;
  assign arr_strb = strb_in & ~pm2[PM2_STRB_OFF];
  assign arr_wrh  = wrh_in & ~pm2[PM2_WRH_OFF];

  for (genvar i = 0; i < CTL_W; i++) begin : g_ctl
    assign arr_ctl[i] = ctl_in[i] & ~pm2[PM2_CTL0_OFF + i];
  end

endmodule

// File: rtl/strobe_idle_pm.sv
module strobe_idle_pm
  import strobe_idle_pkg::*;
#(
  parameter int unsigned IDLE_CLKS = 15,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CTL_W     = 3,
  localparam int unsigned CNT_W    = $clog2(IDLE_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              strb_in,
  input  logic              cs_n,
  input  logic              clk_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic              wrh_in,
  output logic              pwr_down,
  output logic              turbo_on,
  output logic              arr_clk,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [CTL_W-1:0]  arr_ctl,
  output logic              arr_strb,
  output logic              arr_wrh,
  output logic              flash_en,
  output logic              boot_en,
  output logic              sram_en,
  output logic              io_en
);

  logic             cfg_en;
  logic             cfg_pol;
  logic [REG_W-1:0] pm0_q;
  logic [REG_W-1:0] pm2_q;
  logic [CNT_W-1:0] idle_cnt;
  logic             strb_chg;
  logic             at_idle;

  pm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .cfg_en  (cfg_en),
    .cfg_pol (cfg_pol),
    .pm0     (pm0_q),
    .pm2     (pm2_q)
  );

  idle_counter #(.IDLE_CLKS(IDLE_CLKS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .pol      (cfg_pol),
    .strb     (strb_in),
    .cnt      (idle_cnt),
    .strb_chg (strb_chg),
    .at_idle  (at_idle),
    .pd       (pwr_down)
  );

  bus_gate #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_gate (
    .pm0      (pm0_q),
    .pm2      (pm2_q),
    .clk_in   (clk_in),
    .addr_in  (addr_in),
    .ctl_in   (ctl_in),
    .strb_in  (strb_in),
    .wrh_in   (wrh_in),
    .turbo_on (turbo_on),
    .arr_clk  (arr_clk),
    .arr_addr (arr_addr),
    .arr_ctl  (arr_ctl),
    .arr_strb (arr_strb),
    .arr_wrh  (arr_wrh)
  );

  // Memory blocks follow chip-select; the array path does not.
  assign flash_en = ~cs_n;
  assign boot_en  = ~cs_n;
  assign sram_en  = ~cs_n;
  assign io_en    = ~cs_n;

endmodule

// File: rtl/strobe_idle_pm_chk.sv
module strobe_idle_pm_chk
  import strobe_idle_pkg::*;
#(
  parameter int unsigned IDLE_CLKS = 15,
  localparam int unsigned CNT_W = $clog2(IDLE_CLKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic [CNT_W-1:0] idle_cnt,
  input logic             strb_chg,
  input logic             at_idle,
  input logic             pwr_down,
  input logic [REG_W-1:0] pm0_q,
  input logic             arr_clk,
  input logic             cs_n,
  input logic             flash_en,
  input logic             boot_en,
  input logic             sram_en,
  input logic             io_en
);

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !pwr_down);

  a_r3_exact_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(idle_cnt) == CNT_W'(IDLE_CLKS - 1));

  a_r5_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strb_chg |=> idle_cnt == '0);

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down && cfg_en && at_idle && !strb_chg |=> pwr_down);

  a_r8_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pm0_q[PM0_CLK_OFF] |-> !arr_clk);

  a_r10_select_on: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> flash_en && boot_en && sram_en && io_en);

  a_r10_select_off: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !flash_en && !boot_en && !sram_en && !io_en);

endmodule

bind strobe_idle_pm strobe_idle_pm_chk #(.IDLE_CLKS(IDLE_CLKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .idle_cnt (idle_cnt),
  .strb_chg (strb_chg),
  .at_idle  (at_idle),
  .pwr_down (pwr_down),
  .pm0_q    (pm0_q),
  .arr_clk  (arr_clk),
  .cs_n     (cs_n),
  .flash_en (flash_en),
  .boot_en  (boot_en),
  .sram_en  (sram_en),
  .io_en    (io_en)
);

// File: tb/strobe_idle_pm_tb.sv
module strobe_idle_pm_tb;

  localparam int unsigned LIMIT = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       strb_in = 1'b0;
  logic       cs_n = 1'b1;
  logic       clk_in = 1'b1;
  logic [7:0] addr_in = 8'hA5;
  logic [2:0] ctl_in = 3'b111;
  logic       wrh_in = 1'b1;
  logic       pwr_down, turbo_on, arr_clk, arr_strb, arr_wrh;
  logic [7:0] arr_addr;
  logic [2:0] arr_ctl;
  logic       flash_en, boot_en, sram_en, io_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  strobe_idle_pm u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .strb_in(strb_in),
    .cs_n(cs_n), .clk_in(clk_in), .addr_in(addr_in), .ctl_in(ctl_in),
    .wrh_in(wrh_in), .pwr_down(pwr_down), .turbo_on(turbo_on),
    .arr_clk(arr_clk), .arr_addr(arr_addr), .arr_ctl(arr_ctl),
    .arr_strb(arr_strb), .arr_wrh(arr_wrh), .flash_en(flash_en),
    .boot_en(boot_en), .sram_en(sram_en), .io_en(io_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #0.5;
    check(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic clocks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_check("R1 cfg", 2'd0, 8'h00);
    rd_check("R1 pm0", 2'd1, 8'h00);
    rd_check("R1 pm2", 2'd2, 8'h00);
    check("R1 pwr_down", pwr_down, 0);
  endtask

  task automatic t_disabled;
    strb_in = 1'b0;
    clocks(40);
    check("R2 disabled no power-down", pwr_down, 0);
  endtask

  task automatic t_threshold;
    wr_reg(2'd0, 8'h01);
    clocks(LIMIT - 1);
    check("R3 low before 15th clock", pwr_down, 0);
    clocks(1);
    check("R3 high at 15th clock", pwr_down, 1);
    clocks(25);
    check("R6 held while idle", pwr_down, 1);
    strb_in = 1'b1;
    clocks(1);
    check("R5 drops on strobe change", pwr_down, 0);
  endtask

  task automatic t_pulsing;
    for (int i = 0; i < 30; i++) begin
      strb_in = ~strb_in;
      clocks(1);
      check("R5 pulsing suppresses", pwr_down, 0);
    end
    strb_in = 1'b0;
    clocks(1);
    clocks(LIMIT - 1);
    check("R3 low after restart at 14", pwr_down, 0);
    clocks(1);
    check("R3 high after restart at 15", pwr_down, 1);
  endtask

  task automatic t_disable_drop;
    wr_reg(2'd0, 8'h00);
    clocks(1);
    check("R2 clearing enable drops", pwr_down, 0);
  endtask

  task automatic t_polarity;
    strb_in = 1'b0;
    wr_reg(2'd0, 8'h03);
    clocks(30);
    check("R4 non-idle level no count", pwr_down, 0);
    strb_in = 1'b1;
    clocks(1);
    clocks(LIMIT - 1);
    check("R4 high idle at 14", pwr_down, 0);
    clocks(1);
    check("R4 high idle at 15", pwr_down, 1);
    rd_check("R7 cfg readback", 2'd0, 8'h03);
  endtask

  task automatic t_regs;
    wr_reg(2'd1, 8'h5A);
    wr_reg(2'd2, 8'hC3);
    rd_check("R7 pm0 readback", 2'd1, 8'h5A);
    rd_check("R7 pm2 readback", 2'd2, 8'hC3);
    wr_reg(2'd3, 8'hFF);
    rd_check("R7 addr3 reads 0", 2'd3, 8'h00);
    rd_check("R7 addr3 write left pm0", 2'd1, 8'h5A);
    rd_check("R7 addr3 write left pm2", 2'd2, 8'hC3);
    rd_check("R7 addr3 write left cfg", 2'd0, 8'h03);
  endtask

  task automatic t_pm0;
    wr_reg(2'd1, 8'h00);
    check("R8 turbo on", turbo_on, 1);
    check("R8 clk passes", arr_clk, 1);
    wr_reg(2'd1, 8'h08);
    check("R8 turbo off", turbo_on, 0);
    check("R8 clk still passes", arr_clk, 1);
    wr_reg(2'd1, 8'h10);
    check("R8 clk gated", arr_clk, 0);
    check("R8 turbo back on", turbo_on, 1);
  endtask

  task automatic t_pm2;
    strb_in = 1'b1;
    wr_reg(2'd2, 8'h00);
    check("R9 addr passes", arr_addr, 8'hA5);
    wr_reg(2'd2, 8'h01);
    check("R9 addr gated", arr_addr, 8'h00);
    check("R9 ctl untouched by bit0", arr_ctl, 3'b111);
    wr_reg(2'd2, 8'h14);
    check("R9 ctl0 and ctl2 gated", arr_ctl, 3'b010);
    wr_reg(2'd2, 8'h08);
    check("R9 ctl1 gated", arr_ctl, 3'b101);
    wr_reg(2'd2, 8'h60);
    check("R9 strb gated", arr_strb, 0);
    check("R9 wrh gated", arr_wrh, 0);
    wr_reg(2'd2, 8'h82);
    check("R9 bits 1 and 7 gate nothing",
          {arr_addr, arr_ctl, arr_strb, arr_wrh}, {8'hA5, 3'b111, 1'b1, 1'b1});
  endtask

  task automatic t_select;
    cs_n = 1'b0;
    #0.5;
    check("R10 enables on", {flash_en, boot_en, sram_en, io_en}, 4'hF);
    check("R10 array outputs cs low",
          {arr_clk, arr_addr, arr_ctl, arr_strb, arr_wrh},
          {1'b0, 8'hA5, 3'b111, 1'b1, 1'b1});
    cs_n = 1'b1;
    #0.5;
    check("R10 enables off", {flash_en, boot_en, sram_en, io_en}, 4'h0);
    check("R10 array outputs cs high",
          {arr_clk, arr_addr, arr_ctl, arr_strb, arr_wrh, turbo_on},
          {1'b0, 8'hA5, 3'b111, 1'b1, 1'b1, 1'b1});
  endtask

  initial begin
    clocks(3);
    rst_n = 1'b1;
    clocks(1);
    t_reset();
    t_disabled();
    t_threshold();
    t_pulsing();
    t_disable_drop();
    t_polarity();
    t_regs();
    t_pm0();
    t_pm2();
    t_select();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule